// File: doc/BRIEF.md
# Hash Engine Data-Size Accumulator

This block keeps the running count of message bits that a hash engine is still allowed to absorb. Software adds signed increments to the count over a small write-only register bus. Each increment is checked first. If it is accepted, it is folded into the count and fires a one-cycle auto-start pulse. If it is rejected, the write is thrown away and a sticky data-size error is raised. While the count covers at least one full 64-bit word, the error is clear and the input FIFO has data, the block pops one word per cycle and takes 64 off the count.

The count is allowed to go negative. Software uses this to hold data back until a later write, for example once a pad length is known. When the continue-mode bit is set, every resulting count must be a whole number of hash blocks. The block size depends on the algorithm that is selected when the write happens. A second register address has three one-shot reset levels. They clear the count, the error, or both, and each one echoes a single-cycle pulse to the engine.

Top module: `hash_dsize_acc`

## Requirements
- R1: After reset `count_o` is 0, `dsize_err_o`, `start_o` and `take_o` are 0, and `rst_pulse_o` is all zero.
- R2: A write to address 0 adds `wr_data`, read as a signed CNT_W-bit value, to the count. Any number of writes may follow one another, and the new count is visible the cycle after the write.
- R3: While the count is zero or negative, `take_o` stays 0 and the count holds, even when the FIFO is not empty.
- R4: `take_o` is 1 exactly when the count is at least 64, the FIFO is not empty, the error is clear and no count clear is requested. Each take lowers the count by 64, so a count that is a multiple of 64 ends at exactly zero.
- R5: A positive count below 64 never causes a take, and it stays unchanged.
- R6: An increment whose bits [2:0] are not all zero sets the error and leaves the count unchanged. The count's bits [2:0] are always zero.
- R7: The error stays set until a clear. While it is set, `take_o` is 0 and writes to address 0 are discarded, with no count change and no start pulse.
- R8: With `mode_i[3]` (continue mode) set at the write, the resulting count must be a multiple of the block size, or the error is set and the write is discarded. The block size is 512 bits for `mode_i[2:0]` codes 0 to 3 and 6 to 7, and 1024 bits for codes 4 and 5. With `mode_i[3]` clear, only R6 applies.
- R9: `start_o` is 1 for exactly the one cycle after an accepted write to address 0, and stays 0 after a rejected write.
- R10: A write to address 1 acts on its bits. Bit 0 (full reset) and bit 1 (re-initialise) clear both the count and the error. Bit 2 clears only the error. Each set bit drives its `rst_pulse_o` bit high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Register address: 0 = count increment, 1 = reset control |
| wr_data | input | CNT_W (21) | Write data |
| mode_i | input | 4 | [3] continue mode, [2:0] algorithm code |
| fifo_empty_i | input | 1 | Input FIFO holds no word |
| take_o | output | 1 | Pop one 64-bit word from the FIFO this cycle |
| count_o | output | CNT_W (21) | Current signed bit count |
| dsize_err_o | output | 1 | Sticky data-size error |
| start_o | output | 1 | One-cycle auto-start pulse |
| rst_pulse_o | output | 3 | One-cycle echo of the reset-control bits |

## Verification
The bench drives the count negative with words waiting in the FIFO, and also leaves it positive but below one word. A design that only looked at the sign of the count, or at whether it was non-zero, would pop words in these cases. It runs the count down from 192 with ten words queued and checks that it lands exactly on zero with seven words left, which catches an off-by-one in the stop condition. It writes misaligned increments, writes while the error is set, and writes block-misaligned totals under both block sizes. A design that stored rejected writes, let the error fall on its own, or used one block size for every algorithm would show a wrong count, a stray start pulse or a missing error. Finally it applies each reset level separately to catch bits that clear the wrong state or stay high longer than one cycle.

// File: rtl/hash_dsize_pkg.sv
// Shared constants and helpers for the data-size accumulator.
// Assumes a 3-bit algorithm code; codes 4 and 5 select the wide block.
package hash_dsize_pkg;
    localparam int unsigned ADDR_DSIZE  = 0;
    localparam int unsigned ADDR_RSTCTL = 1;
    localparam int unsigned RST_BITS    = 3;
    localparam int unsigned RB_FULL     = 0;
    localparam int unsigned RB_REINIT   = 1;
    localparam int unsigned RB_ERRCLR   = 2;
    localparam int unsigned OFS_BITS    = 3;
    localparam int unsigned ALG_W       = 3;

    typedef enum logic [ALG_W-1:0] {
        ALG_MD5    = 3'd0,
        ALG_SHA1   = 3'd1,
        ALG_SHA224 = 3'd2,
        ALG_SHA256 = 3'd3,
        ALG_SHA384 = 3'd4,
        ALG_SHA512 = 3'd5
    } hash_alg_e;

    // log2 of the hash block size in bits for an algorithm code
    function automatic int unsigned blk_log2(logic [ALG_W-1:0] alg);
        if (alg == ALG_SHA384 || alg == ALG_SHA512)
            return 10;
        return 9;
    endfunction
endpackage

// File: rtl/dsize_bus_dec.sv
// Register-bus decoder: splits writes into count increments and
// reset-control requests, and holds the self-clearing pulse bits.
// Assumes one write per cycle, no read path.
module dsize_bus_dec
    import hash_dsize_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned CNT_W  = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic                dsize_wr_o,
    output logic [CNT_W-1:0]    inc_o,
    output logic                clr_cnt_o,
    output logic                clr_err_o,
    output logic [RST_BITS-1:0] pulse_o
);
    logic                rst_wr;
    logic [RST_BITS-1:0] req_bits;

    // Address decode of the two registers
    always_comb begin
        dsize_wr_o = wr_en && (wr_addr == ADDR_W'(ADDR_DSIZE));
        rst_wr     = wr_en && (wr_addr == ADDR_W'(ADDR_RSTCTL));
        inc_o      = wr_data;
        req_bits   = rst_wr ? wr_data[RST_BITS-1:0] : '0;
        clr_cnt_o  = req_bits[RB_FULL] | req_bits[RB_REINIT];
        clr_err_o  = |req_bits;
    end

    genvar gi;
    generate
        for (gi = 0; gi < RST_BITS; gi++) begin : g_pulse
            // One self-clearing pulse flop per reset level
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pulse_o[gi] <= 1'b0;
                else
                    pulse_o[gi] <= req_bits[gi];
            end

            // R10: a pulse bit lasts one cycle unless requested again
            a_r10_pulse_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (pulse_o[gi] && !req_bits[gi]) |=> !pulse_o[gi]);
        end
    endgenerate
endmodule

// File: rtl/dsize_check.sv
// Combinational validator: forms the candidate count for a write and
// flags misaligned increments and, in continue mode, block misalignment.
// Assumes the take in the same cycle is already decided.
module dsize_check
    import hash_dsize_pkg::*;
#(
    parameter int unsigned CNT_W     = 21,
    parameter int unsigned WORD_BITS = 64
) (
    input  logic signed [CNT_W-1:0] count_i,
    input  logic                    take_i,
    input  logic signed [CNT_W-1:0] inc_i,
    input  logic                    cont_i,
    input  logic [ALG_W-1:0]        alg_i,
    output logic signed [CNT_W-1:0] sum_o,
    output logic                    err_o
);
    localparam logic signed [CNT_W-1:0] WORD_S = CNT_W'(WORD_BITS);

    logic [CNT_W-1:0] blk_mask;
    logic             ofs_bad;
    logic             blk_bad;

    // Candidate count and the two validity checks
    always_comb begin
        sum_o    = count_i - (take_i ? WORD_S : '0) + inc_i;
        blk_mask = (CNT_W'(1) << blk_log2(alg_i)) - CNT_W'(1);
        ofs_bad  = |inc_i[OFS_BITS-1:0];
        blk_bad  = cont_i && ((sum_o & blk_mask) != '0);
        err_o    = ofs_bad | blk_bad;
    end
endmodule

// File: rtl/dsize_accum.sv
// Count register, sticky error and word-consumption handshake.
// Assumes clear requests and count writes never share a cycle.
module dsize_accum
    import hash_dsize_pkg::*;
#(
    parameter int unsigned CNT_W     = 21,
    parameter int unsigned WORD_BITS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dsize_wr_i,
    input  logic signed [CNT_W-1:0] inc_i,
    input  logic                    cont_i,
    input  logic [ALG_W-1:0]        alg_i,
    input  logic                    clr_cnt_i,
    input  logic                    clr_err_i,
    input  logic                    fifo_empty_i,
    output logic                    take_o,
    output logic signed [CNT_W-1:0] count_o,
    output logic                    err_o,
    output logic                    start_o
);
    localparam logic signed [CNT_W-1:0] WORD_S = CNT_W'(WORD_BITS);

    logic signed [CNT_W-1:0] sum;
    logic                    chk_err;
    logic                    accept;
    logic                    reject;

    dsize_check #(
        .CNT_W     (CNT_W),
        .WORD_BITS (WORD_BITS)
    ) u_check (
        .count_i (count_o),
        .take_i  (take_o),
        .inc_i   (inc_i),
        .cont_i  (cont_i),
        .alg_i   (alg_i),
        .sum_o   (sum),
        .err_o   (chk_err)
    );

    // Consumption grant and write classification
    always_comb begin
        take_o = !err_o && !fifo_empty_i && !clr_cnt_i && (count_o >= WORD_S);
        accept = dsize_wr_i && !err_o && !chk_err;
        reject = dsize_wr_i && !err_o && chk_err;
    end

    // Count, error and start state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            err_o   <= 1'b0;
            start_o <= 1'b0;
        end else begin
            if (clr_cnt_i)
                count_o <= '0;
            else if (accept)
                count_o <= sum;
            else if (take_o)
                count_o <= count_o - WORD_S;

            if (clr_err_i)
                err_o <= 1'b0;
            else if (reject)
                err_o <= 1'b1;

            start_o <= accept;
        end
    end

    // R6: offset bits of the count never become non-zero
    a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        count_o[OFS_BITS-1:0] == '0);

    // R4: a lone take lowers the count by one word
    a_r4_take_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !dsize_wr_i && !clr_cnt_i) |=> (count_o == $past(count_o) - WORD_S));

    // R3: no take while the count is not positive
    a_r3_no_take_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o <= 0) |-> !take_o);

    // R7: error is sticky until cleared, and blocks consumption
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_err_i) |=> err_o);
    a_r7_no_take_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !take_o);

    // R9: start pulse only follows a count write made without error
    a_r9_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_o) |-> ($past(dsize_wr_i) && !err_o));
endmodule

// File: rtl/hash_dsize_acc.sv
// Top of the data-size accumulator: wires the bus decoder to the
// accumulator and exposes the FIFO pop, count, error, start and
// reset-pulse outputs. Assumes mode_i is stable in the write cycle.
module hash_dsize_acc
    import hash_dsize_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned CNT_W     = 21,
    parameter int unsigned WORD_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [ALG_W:0]      mode_i,
    input  logic                fifo_empty_i,
    output logic                take_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                dsize_err_o,
    output logic                start_o,
    output logic [RST_BITS-1:0] rst_pulse_o
);
    logic                    dsize_wr;
    logic [CNT_W-1:0]        inc;
    logic                    clr_cnt;
    logic                    clr_err;
    logic signed [CNT_W-1:0] count_s;

    dsize_bus_dec #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .dsize_wr_o (dsize_wr),
        .inc_o      (inc),
        .clr_cnt_o  (clr_cnt),
        .clr_err_o  (clr_err),
        .pulse_o    (rst_pulse_o)
    );

    dsize_accum #(
        .CNT_W     (CNT_W),
        .WORD_BITS (WORD_BITS)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .dsize_wr_i   (dsize_wr),
        .inc_i        (inc),
        .cont_i       (mode_i[ALG_W]),
        .alg_i        (mode_i[ALG_W-1:0]),
        .clr_cnt_i    (clr_cnt),
        .clr_err_i    (clr_err),
        .fifo_empty_i (fifo_empty_i),
        .take_o       (take_o),
        .count_o      (count_s),
        .err_o        (dsize_err_o),
        .start_o      (start_o)
    );

    // Present the count as a plain vector
    always_comb count_o = count_s;
endmodule

// File: tb/hash_dsize_acc_bench.sv
module hash_dsize_acc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [20:0] wr_data = '0;
    logic [3:0]  mode_i = '0;
    logic        fifo_empty_i;
    logic        take_o;
    logic [20:0] count_o;
    logic        dsize_err_o;
    logic        start_o;
    logic [2:0]  rst_pulse_o;

    int vectors = 0;
    int errors  = 0;
    int fifo_level = 0;
    logic fifo_load = 1'b0;
    int   fifo_load_val = 0;
    logic signed [20:0] cnt_s;

    assign cnt_s = count_o;
    assign fifo_empty_i = (fifo_level == 0);

    always #4 clk = ~clk;

    hash_dsize_acc u_hash_dsize_acc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_i(mode_i), .fifo_empty_i(fifo_empty_i),
        .take_o(take_o), .count_o(count_o), .dsize_err_o(dsize_err_o),
        .start_o(start_o), .rst_pulse_o(rst_pulse_o)
    );

    // FIFO stub: load on request, otherwise drain on each take
    always @(posedge clk) begin
        if (fifo_load) fifo_level <= fifo_load_val;
        else if (take_o) fifo_level <= fifo_level - 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d[20:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_fifo(input int n);
        @(negedge clk);
        fifo_load = 1'b1; fifo_load_val = n;
        @(negedge clk);
        fifo_load = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 count", int'(cnt_s), 0);
        check("R1 err", int'(dsize_err_o), 0);
        check("R1 start", int'(start_o), 0);
        check("R1 take", int'(take_o), 0);
        check("R1 pulse", int'(rst_pulse_o), 0);
    endtask

    task automatic t_accum;
        write(0, 512);
        check("R2 count 512", int'(cnt_s), 512);
        check("R9 start", int'(start_o), 1);
        write(0, 256);
        check("R2 count 768", int'(cnt_s), 768);
        wait_cyc(1);
        check("R9 start one cycle", int'(start_o), 0);
        write(0, -1024);
        check("R2 count -256", int'(cnt_s), -256);
        write(1, 3'b010);
        check("R10 reinit pulse", int'(rst_pulse_o), 3'b010);
        check("R10 reinit count", int'(cnt_s), 0);
        wait_cyc(1);
        check("R10 pulse clears", int'(rst_pulse_o), 0);
    endtask

    task automatic t_negative;
        write(0, -128);
        load_fifo(5);
        wait_cyc(3);
        check("R3 count holds", int'(cnt_s), -128);
        check("R3 no take", int'(take_o), 0);
        check("R3 fifo untouched", fifo_level, 5);
        write(0, 192);
        check("R4 count 64", int'(cnt_s), 64);
        check("R4 take", int'(take_o), 1);
        wait_cyc(1);
        check("R4 count 0", int'(cnt_s), 0);
        check("R4 fifo 4", fifo_level, 4);
        check("R3 no take at 0", int'(take_o), 0);
        load_fifo(0);
    endtask

    task automatic t_consume;
        load_fifo(10);
        write(0, 192);
        check("R4 count 192", int'(cnt_s), 192);
        wait_cyc(3);
        check("R4 ends at 0", int'(cnt_s), 0);
        check("R4 fifo 7", fifo_level, 7);
        check("R4 take stops", int'(take_o), 0);
        write(0, 32);
        check("R5 no take", int'(take_o), 0);
        wait_cyc(2);
        check("R5 count 32", int'(cnt_s), 32);
        check("R5 fifo 7", fifo_level, 7);
        write(0, -32);
        load_fifo(0);
        write(0, 128);
        wait_cyc(2);
        check("R4 empty no take", int'(take_o), 0);
        check("R4 empty count", int'(cnt_s), 128);
        load_fifo(2);
        wait_cyc(2);
        check("R4 drained count", int'(cnt_s), 0);
        check("R4 drained fifo", fifo_level, 0);
    endtask

    task automatic t_lowbits;
        write(0, 4);
        check("R6 err", int'(dsize_err_o), 1);
        check("R6 count kept", int'(cnt_s), 0);
        check("R9 no start on err", int'(start_o), 0);
        write(1, 3'b100);
        check("R10 errclr pulse", int'(rst_pulse_o), 3'b100);
        check("R10 err cleared", int'(dsize_err_o), 0);
        write(0, 8);
        check("R6 aligned 8", int'(cnt_s), 8);
        check("R6 no err 8", int'(dsize_err_o), 0);
        write(0, -8);
    endtask

    task automatic t_sticky;
        write(0, 128);
        write(0, 12);
        check("R6 err 12", int'(dsize_err_o), 1);
        check("R6 count 128", int'(cnt_s), 128);
        write(0, 64);
        check("R7 write ignored", int'(cnt_s), 128);
        check("R7 no start", int'(start_o), 0);
        load_fifo(3);
        wait_cyc(2);
        check("R7 err sticky", int'(dsize_err_o), 1);
        check("R7 no take", int'(take_o), 0);
        check("R7 fifo 3", fifo_level, 3);
        write(1, 3'b100);
        check("R10 errclr keeps count", int'(cnt_s), 128);
        check("R7 take resumes", int'(take_o), 1);
        wait_cyc(2);
        check("R7 count 0", int'(cnt_s), 0);
        check("R7 fifo 1", fifo_level, 1);
        load_fifo(0);
    endtask

    task automatic t_cont;
        mode_i = 4'b1011;
        write(0, 1024);
        check("R8 512 ok", int'(cnt_s), 1024);
        check("R8 start", int'(start_o), 1);
        write(0, 256);
        check("R8 512 misalign err", int'(dsize_err_o), 1);
        check("R8 count kept", int'(cnt_s), 1024);
        write(1, 3'b010);
        mode_i = 4'b1101;
        write(0, 512);
        check("R8 1024 misalign err", int'(dsize_err_o), 1);
        check("R8 1024 count 0", int'(cnt_s), 0);
        write(1, 3'b010);
        write(0, 2048);
        check("R8 1024 ok", int'(cnt_s), 2048);
        write(0, -1024);
        check("R8 1024 neg ok", int'(cnt_s), 1024);
        check("R8 no err", int'(dsize_err_o), 0);
        mode_i = 4'b0001;
        write(0, 8);
        check("R8 cont off", int'(cnt_s), 1032);
        check("R8 cont off no err", int'(dsize_err_o), 0);
        write(1, 3'b010);
        mode_i = 4'b0000;
    endtask

    task automatic t_full;
        write(0, 64);
        write(0, 4);
        check("R6 err before full", int'(dsize_err_o), 1);
        write(1, 3'b001);
        check("R10 full pulse", int'(rst_pulse_o), 3'b001);
        check("R10 full count", int'(cnt_s), 0);
        check("R10 full err", int'(dsize_err_o), 0);
        wait_cyc(1);
        check("R10 full pulse clears", int'(rst_pulse_o), 0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accum();
        t_negative();
        t_consume();
        t_lowbits();
        t_sticky();
        t_cont();
        t_full();
        summary();
        $finish;
    end
endmodule